// File: doc/BRIEF.md
# Two-Gate Multi-CPU Interrupt Controller

This block takes level-sensitive device interrupt lines and delivers them to a small group of CPUs, four by default, on one IRQ and one FIQ output per CPU. A source can reach a CPU only when two independent gates are both open. The first is a global per-source enable. The second is that CPU's routing bit in the source's control word. Software changes the enables and the per-CPU gates by writing a source number to set and clear registers. It does not write bitmaps.

The block has two register views, and a single bus port reaches both. The global view is the same for every CPU. The per-CPU view is banked on the `busCpu` input, so one address reaches the registers of whichever CPU issues the access. Source numbers below `NPRIV` are private. Each CPU has its own input line for each private source. Higher numbers are shared device lines. Each CPU also has a 32-bit doorbell cause register and a doorbell mask register. A software-trigger register in the global view sets doorbells. An acknowledge register reports the lowest-numbered source that is currently deliverable to the reading CPU.

Reads are combinational: `busRdata` is valid in the same cycle as a read request. Writes take effect at the next rising clock edge.

Top module: `dual_gate_intc`

## Requirements
- R1: CPU n's IRQ output is high while any source is pending, has its global enable set, and has routing bit n (bit n of its control word) set. It is also high while any bit is set in both CPU n's doorbell cause and doorbell mask. Sources are level sensitive, so the output falls when the pending line falls.
- R2: A global write to offset 0x030 sets the enable of the source numbered by `busWdata[9:0]`, and a global write to 0x034 clears it. A number of `NSRC` or more is ignored, even when its low bits alias a valid source.
- R3: The control word of source s is at global offset 0x100 + 4*s. Bit n routes the source to CPU n's IRQ, and bit 8+n routes it to CPU n's FIQ. The word reads back with all other bits zero.
- R4: A per-CPU write to 0x048 sets, and a write to 0x04C clears, the IRQ routing bit of the issuing CPU (`busCpu`) for the source numbered by `busWdata[9:0]`. The routing bits of the other CPUs do not change. The result is visible in the control word readback.
- R5: CPU n's FIQ output is high while a pending, globally enabled source has bit 8+n of its control word set. Doorbells never drive FIQ.
- R6: For a source s below `NPRIV`, the pending line for CPU n is `privIrq[n*NPRIV+s]`. For a source s of `NPRIV` or more, the pending line is `sharedIrq[s-NPRIV]` for every CPU.
- R7: A per-CPU read of 0x044 returns the lowest-numbered source that is pending, enabled and IRQ-routed to the reading CPU. It returns 0x3FF when no source qualifies, and the read has no side effect.
- R8: A global write to 0x004 sets doorbell bit `busWdata[4:0]` in the cause register of every CPU n whose bit `busWdata[24+n]` is set.
- R9: The per-CPU doorbell cause register at 0x008 reads back. A write to it clears the bits written as 0 and leaves the bits written as 1 unchanged. The per-CPU doorbell mask at 0x00C is a plain read/write register.
- R10: After reset, all enables, routing bits, causes and masks are zero, both outputs are low, and the acknowledge register reads 0x3FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busValid | input | 1 | Register access request this cycle |
| busWrite | input | 1 | 1 = write, 0 = read |
| busPerCpu | input | 1 | 1 = banked per-CPU view, 0 = global view |
| busCpu | input | 2 | ID of the CPU issuing the access |
| busAddr | input | 12 | Byte offset within the selected view |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| privIrq | input | 112 | Private source lines, NPRIV per CPU |
| sharedIrq | input | 8 | Shared device source lines |
| irqOut | output | 4 | IRQ line per CPU |
| fiqOut | output | 4 | FIQ line per CPU |

## Verification
The hardest case to reach from the ports is a per-CPU gate change that must leave the gates of the other CPUs alone. This happens while a private source is pending on one CPU's line and not on another's. The stimulus enables a private source globally and opens it only from CPU 2. It then raises the source's line first for CPU 1 and then for CPU 2, and closes the gate from CPU 3 before closing it from CPU 2, reading the control word back after each step. A second hard case is a set-enable number above the source count whose low bits alias source 0. This is checked with source 0 already pending and routed, so any wrong enable would show on the IRQ line. A behavioural model in the bench predicts every output on every cycle throughout the run.

// File: rtl/dgi_pkg.sv
package dgi_pkg;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;
  localparam int SRC_ID_W = 10;
  localparam logic [SRC_ID_W-1:0] ACK_NONE = 10'h3FF;

  // global view
  localparam logic [ADDR_W-1:0] OFS_SW_TRIG  = 12'h004;
  localparam logic [ADDR_W-1:0] OFS_EN_SET   = 12'h030;
  localparam logic [ADDR_W-1:0] OFS_EN_CLR   = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_CTL_BASE = 12'h100;
  // banked per-CPU view
  localparam logic [ADDR_W-1:0] OFS_DB_CAUSE = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_DB_MASK  = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_ACK      = 12'h044;
  localparam logic [ADDR_W-1:0] OFS_GATE_SET = 12'h048;
  localparam logic [ADDR_W-1:0] OFS_GATE_CLR = 12'h04C;

  typedef enum logic [2:0] {
    RD_NONE, RD_SRC_CTL, RD_DB_CAUSE, RD_DB_MASK, RD_ACK
  } rdSel_e;

  typedef struct packed {
    logic   enSet;
    logic   enClr;
    logic   ctlWr;
    logic   gateSet;
    logic   gateClr;
    logic   swTrig;
    logic   causeWr;
    logic   dbMaskWr;
    rdSel_e rdSel;
  } strobe_t;
endpackage

// File: rtl/dgi_ctrl.sv
module dgi_ctrl
  import dgi_pkg::*;
#(
  parameter int NSRC   = 36,
  parameter int SIDX_W = 6
) (
  input  logic                busValid,
  input  logic                busWrite,
  input  logic                busPerCpu,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [SRC_ID_W-1:0] numIn,
  output strobe_t             stb,
  output logic [SIDX_W-1:0]   srcIdx
);
  logic              numOk;
  logic [ADDR_W-1:0] ctlOff;
  logic              ctlHit;
  logic              gWr, gRd, pWr, pRd;

  assign numOk  = numIn < SRC_ID_W'(NSRC);
  assign ctlOff = busAddr - OFS_CTL_BASE;
  assign ctlHit = (busAddr >= OFS_CTL_BASE) && (ctlOff[1:0] == 2'b00) &&
                  (ctlOff[ADDR_W-1:2] < (ADDR_W-2)'(NSRC));

  assign gWr = busValid &&  busWrite && !busPerCpu;
  assign gRd = busValid && !busWrite && !busPerCpu;
  assign pWr = busValid &&  busWrite &&  busPerCpu;
  assign pRd = busValid && !busWrite &&  busPerCpu;

  assign srcIdx = (!busPerCpu && ctlHit) ? ctlOff[2 +: SIDX_W] : numIn[SIDX_W-1:0];

  always_comb begin
    stb          = '0;
    stb.rdSel    = RD_NONE;
    stb.enSet    = gWr && busAddr == OFS_EN_SET && numOk;
    stb.enClr    = gWr && busAddr == OFS_EN_CLR && numOk;
    stb.swTrig   = gWr && busAddr == OFS_SW_TRIG;
    stb.ctlWr    = gWr && ctlHit;
    stb.gateSet  = pWr && busAddr == OFS_GATE_SET && numOk;
    stb.gateClr  = pWr && busAddr == OFS_GATE_CLR && numOk;
    stb.causeWr  = pWr && busAddr == OFS_DB_CAUSE;
    stb.dbMaskWr = pWr && busAddr == OFS_DB_MASK;
    if (gRd && ctlHit)                   stb.rdSel = RD_SRC_CTL;
    else if (pRd && busAddr == OFS_DB_CAUSE) stb.rdSel = RD_DB_CAUSE;
    else if (pRd && busAddr == OFS_DB_MASK)  stb.rdSel = RD_DB_MASK;
    else if (pRd && busAddr == OFS_ACK)      stb.rdSel = RD_ACK;
  end
endmodule

// File: rtl/dgi_datapath.sv
module dgi_datapath
  import dgi_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NSRC   = 36,
  parameter int NPRIV  = 28,
  parameter int CPU_W  = 2,
  parameter int SIDX_W = 6
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  strobe_t                 stb,
  input  logic [SIDX_W-1:0]       srcIdx,
  input  logic [CPU_W-1:0]        cpu,
  input  logic [DATA_W-1:0]       wdata,
  input  logic [NCPU*NPRIV-1:0]   privIrq,
  input  logic [NSRC-NPRIV-1:0]   sharedIrq,
  output logic [DATA_W-1:0]       rdata,
  output logic [NCPU-1:0]         irqOut,
  output logic [NCPU-1:0]         fiqOut
);
  logic [NSRC-1:0]                enable;
  logic [NSRC-1:0][NCPU-1:0]      irqRoute;
  logic [NSRC-1:0][NCPU-1:0]      fiqRoute;
  logic [NCPU-1:0][DATA_W-1:0]    cause;
  logic [NCPU-1:0][DATA_W-1:0]    dbMask;
  logic [NCPU-1:0][NSRC-1:0]      pendVec, irqQual, fiqQual;
  logic [DATA_W-1:0]              ctlWord;
  logic [SRC_ID_W-1:0]            ackId;

  // pending line selection: private sources are banked per CPU
  for (genvar c = 0; c < NCPU; c++) begin : gCpu
    for (genvar s = 0; s < NSRC; s++) begin : gSrc
      if (s < NPRIV) begin : gPriv
        assign pendVec[c][s] = privIrq[c*NPRIV+s];
      end else begin : gShared
        assign pendVec[c][s] = sharedIrq[s-NPRIV];
      end
      assign irqQual[c][s] = pendVec[c][s] & enable[s] & irqRoute[s][c];
      assign fiqQual[c][s] = pendVec[c][s] & enable[s] & fiqRoute[s][c];
    end
    assign irqOut[c] = (|irqQual[c]) | (|(cause[c] & dbMask[c]));
    assign fiqOut[c] = |fiqQual[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enable   <= '0;
      irqRoute <= '0;
      fiqRoute <= '0;
      cause    <= '0;
      dbMask   <= '0;
    end else begin
      if (stb.enSet)   enable[srcIdx] <= 1'b1;
      if (stb.enClr)   enable[srcIdx] <= 1'b0;
      if (stb.ctlWr) begin
        for (int c = 0; c < NCPU; c++) begin
          irqRoute[srcIdx][c] <= wdata[c];
          fiqRoute[srcIdx][c] <= wdata[8+c];
        end
      end
      if (stb.gateSet) irqRoute[srcIdx][cpu] <= 1'b1;
      if (stb.gateClr) irqRoute[srcIdx][cpu] <= 1'b0;
      if (stb.swTrig) begin
        for (int c = 0; c < NCPU; c++)
          if (wdata[24+c]) cause[c][wdata[4:0]] <= 1'b1;
      end
      if (stb.causeWr)  cause[cpu]  <= cause[cpu] & wdata;
      if (stb.dbMaskWr) dbMask[cpu] <= wdata;
    end
  end

  always_comb begin
    ctlWord = '0;
    for (int c = 0; c < NCPU; c++) begin
      ctlWord[c]   = irqRoute[srcIdx][c];
      ctlWord[8+c] = fiqRoute[srcIdx][c];
    end
  end

  always_comb begin
    ackId = ACK_NONE;
    for (int s = NSRC-1; s >= 0; s--)
      if (irqQual[cpu][s]) ackId = SRC_ID_W'(s);
  end

  always_comb begin
    case (stb.rdSel)
      RD_SRC_CTL:  rdata = ctlWord;
      RD_DB_CAUSE: rdata = cause[cpu];
      RD_DB_MASK:  rdata = dbMask[cpu];
      RD_ACK:      rdata = DATA_W'(ackId);
      default:     rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_gate_intc.sv
module dual_gate_intc
  import dgi_pkg::*;
#(
  parameter int NCPU  = 4,
  parameter int NSRC  = 36,
  parameter int NPRIV = 28
) (
  input  logic                                 clk,
  input  logic                                 rstN,
  input  logic                                 busValid,
  input  logic                                 busWrite,
  input  logic                                 busPerCpu,
  input  logic [((NCPU > 1) ? $clog2(NCPU) : 1)-1:0] busCpu,
  input  logic [ADDR_W-1:0]                    busAddr,
  input  logic [DATA_W-1:0]                    busWdata,
  output logic [DATA_W-1:0]                    busRdata,
  input  logic [NCPU*NPRIV-1:0]                privIrq,
  input  logic [NSRC-NPRIV-1:0]                sharedIrq,
  output logic [NCPU-1:0]                      irqOut,
  output logic [NCPU-1:0]                      fiqOut
);
  localparam int CPU_W  = (NCPU > 1) ? $clog2(NCPU) : 1;
  localparam int SIDX_W = $clog2(NSRC);

  strobe_t           stb;
  logic [SIDX_W-1:0] srcIdx;

  dgi_ctrl #(.NSRC(NSRC), .SIDX_W(SIDX_W)) u_ctrl (
    .busValid (busValid),
    .busWrite (busWrite),
    .busPerCpu(busPerCpu),
    .busAddr  (busAddr),
    .numIn    (busWdata[SRC_ID_W-1:0]),
    .stb      (stb),
    .srcIdx   (srcIdx)
  );

  dgi_datapath #(
    .NCPU(NCPU), .NSRC(NSRC), .NPRIV(NPRIV), .CPU_W(CPU_W), .SIDX_W(SIDX_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .srcIdx   (srcIdx),
    .cpu      (busCpu),
    .wdata    (busWdata),
    .privIrq  (privIrq),
    .sharedIrq(sharedIrq),
    .rdata    (busRdata),
    .irqOut   (irqOut),
    .fiqOut   (fiqOut)
  );
endmodule

// File: rtl/dgi_checker.sv
module dgi_checker
  import dgi_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NSRC   = 36,
  parameter int NPRIV  = 28,
  parameter int CPU_W  = 2,
  parameter int SIDX_W = 6
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        busValid,
  input logic                        busWrite,
  input logic                        busPerCpu,
  input logic [CPU_W-1:0]            busCpu,
  input logic [ADDR_W-1:0]           busAddr,
  input logic [DATA_W-1:0]           busWdata,
  input logic [DATA_W-1:0]           busRdata,
  input logic [NCPU*NPRIV-1:0]       privIrq,
  input logic [NSRC-NPRIV-1:0]       sharedIrq,
  input logic [NCPU-1:0]             fiqOut,
  input logic [NSRC-1:0]             enable,
  input logic [NCPU-1:0][DATA_W-1:0] cause
);
  logic              quiet;
  logic              enWrite, trigWrite, causeZeroWr, ackRead;
  logic [SIDX_W-1:0] lastNum;
  logic [4:0]        lastBit;
  logic [CPU_W-1:0]  lastCpu;

  assign quiet       = (privIrq == '0) && (sharedIrq == '0);
  assign enWrite     = busValid && busWrite && !busPerCpu && busAddr == OFS_EN_SET &&
                       busWdata[SRC_ID_W-1:0] < SRC_ID_W'(NSRC);
  assign trigWrite   = busValid && busWrite && !busPerCpu && busAddr == OFS_SW_TRIG;
  assign causeZeroWr = busValid && busWrite && busPerCpu && busAddr == OFS_DB_CAUSE &&
                       busWdata == '0;
  assign ackRead     = busValid && !busWrite && busPerCpu && busAddr == OFS_ACK;

  always_ff @(posedge clk) begin
    lastNum <= busWdata[SIDX_W-1:0];
    lastBit <= busWdata[4:0];
    lastCpu <= busCpu;
  end

  assert_enable_set_R2: assert property (@(posedge clk) disable iff (!rstN)
    enWrite |=> enable[lastNum]);

  assert_fiq_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    quiet |-> fiqOut == '0);

  assert_ack_none_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackRead && quiet) |-> busRdata == DATA_W'(ACK_NONE));

  assert_cause_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    causeZeroWr |=> cause[lastCpu] == '0);

  for (genvar c = 0; c < NCPU; c++) begin : gTrig
    assert_trigger_sets_R8: assert property (@(posedge clk) disable iff (!rstN)
      (trigWrite && busWdata[24+c]) |=> cause[c][lastBit]);
  end
endmodule

bind dual_gate_intc dgi_checker #(
  .NCPU(NCPU), .NSRC(NSRC), .NPRIV(NPRIV), .CPU_W(CPU_W), .SIDX_W(SIDX_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busValid (busValid),
  .busWrite (busWrite),
  .busPerCpu(busPerCpu),
  .busCpu   (busCpu),
  .busAddr  (busAddr),
  .busWdata (busWdata),
  .busRdata (busRdata),
  .privIrq  (privIrq),
  .sharedIrq(sharedIrq),
  .fiqOut   (fiqOut),
  .enable   (u_dp.enable),
  .cause    (u_dp.cause)
);

// File: tb/dual_gate_intc_test.sv
module dual_gate_intc_test;
  localparam int NCPU = 4, NSRC = 36, NPRIV = 28;

  logic        clk = 0, rstN = 0;
  logic        busValid = 0, busWrite = 0, busPerCpu = 0;
  logic [1:0]  busCpu = 0;
  logic [11:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic [NCPU*NPRIV-1:0] privIrq = '0;
  logic [NSRC-NPRIV-1:0] sharedIrq = '0;
  logic [NCPU-1:0] irqOut, fiqOut;

  int checks = 0, errors = 0;
  bit running = 0;

  // behavioural reference state
  bit         mEn[NSRC];
  bit         mIrqR[NSRC][NCPU];
  bit         mFiqR[NSRC][NCPU];
  bit [31:0]  mCause[NCPU];
  bit [31:0]  mMask[NCPU];

  always #5 clk = ~clk;

  dual_gate_intc uut (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busPerCpu(busPerCpu), .busCpu(busCpu), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .privIrq(privIrq),
    .sharedIrq(sharedIrq), .irqOut(irqOut), .fiqOut(fiqOut)
  );

  function automatic bit pend(int c, int s);
    if (s < NPRIV) return privIrq[c*NPRIV+s];
    return sharedIrq[s-NPRIV];
  endfunction

  function automatic bit expIrq(int c);
    bit r = (mCause[c] & mMask[c]) != 0;
    for (int s = 0; s < NSRC; s++) if (pend(c, s) && mEn[s] && mIrqR[s][c]) r = 1;
    return r;
  endfunction

  function automatic bit expFiq(int c);
    bit r = 0;
    for (int s = 0; s < NSRC; s++) if (pend(c, s) && mEn[s] && mFiqR[s][c]) r = 1;
    return r;
  endfunction

  function automatic int expAck(int c);
    for (int s = 0; s < NSRC; s++) if (pend(c, s) && mEn[s] && mIrqR[s][c]) return s;
    return 'h3FF;
  endfunction

  function automatic bit [31:0] mRead(bit p, int c, int a);
    bit [31:0] w = 0;
    if (!p && a >= 'h100 && a[1:0] == 0 && (a - 'h100) / 4 < NSRC) begin
      for (int k = 0; k < NCPU; k++) begin
        w[k] = mIrqR[(a-'h100)/4][k];
        w[8+k] = mFiqR[(a-'h100)/4][k];
      end
    end else if (p && a == 'h008) w = mCause[c];
    else if (p && a == 'h00C) w = mMask[c];
    else if (p && a == 'h044) w = expAck(c);
    return w;
  endfunction

  task automatic mApply(bit p, int c, int a, bit [31:0] d);
    int n = d[9:0];
    if (!p) begin
      if (a == 'h030 && n < NSRC) mEn[n] = 1;
      else if (a == 'h034 && n < NSRC) mEn[n] = 0;
      else if (a == 'h004) begin
        for (int k = 0; k < NCPU; k++) if (d[24+k]) mCause[k][d[4:0]] = 1;
      end else if (a >= 'h100 && a[1:0] == 0 && (a - 'h100) / 4 < NSRC) begin
        for (int k = 0; k < NCPU; k++) begin
          mIrqR[(a-'h100)/4][k] = d[k];
          mFiqR[(a-'h100)/4][k] = d[8+k];
        end
      end
    end else begin
      if (a == 'h048 && n < NSRC) mIrqR[n][c] = 1;
      else if (a == 'h04C && n < NSRC) mIrqR[n][c] = 0;
      else if (a == 'h008) mCause[c] = mCause[c] & d;
      else if (a == 'h00C) mMask[c] = d;
    end
  endtask

  task automatic check(string tag, bit [31:0] got, bit [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  // per-cycle comparison of outputs against the model
  always @(negedge clk) begin
    if (running) begin
      for (int c = 0; c < NCPU; c++) begin
        check($sformatf("R1 irqOut[%0d] per-cycle", c), 32'(irqOut[c]), 32'(expIrq(c)));
        check($sformatf("R5 fiqOut[%0d] per-cycle", c), 32'(fiqOut[c]), 32'(expFiq(c)));
      end
    end
  end

  task automatic wr(bit p, int c, int a, bit [31:0] d);
    @(negedge clk);
    busValid = 1; busWrite = 1; busPerCpu = p; busCpu = 2'(c);
    busAddr = 12'(a); busWdata = d;
    @(posedge clk); #1;
    busValid = 0; busWrite = 0;
    mApply(p, c, a, d);
  endtask

  task automatic rd(bit p, int c, int a, bit [31:0] exp, string tag);
    @(negedge clk);
    busValid = 1; busWrite = 0; busPerCpu = p; busCpu = 2'(c); busAddr = 12'(a);
    #1;
    check({tag, " read model"}, busRdata, mRead(p, c, a));
    check({tag, " read"}, busRdata, exp);
    @(posedge clk); #1;
    busValid = 0;
  endtask

  task automatic outs(string tag, bit [3:0] eIrq, bit [3:0] eFiq);
    @(negedge clk); #1;
    check({tag, " irqOut"}, 32'(irqOut), 32'(eIrq));
    check({tag, " fiqOut"}, 32'(fiqOut), 32'(eFiq));
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual running expected finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSRC; s++) begin
      mEn[s] = 0;
      for (int c = 0; c < NCPU; c++) begin mIrqR[s][c] = 0; mFiqR[s][c] = 0; end
    end
    for (int c = 0; c < NCPU; c++) begin mCause[c] = 0; mMask[c] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1; running = 1;

    // R10 reset state
    outs("R10 reset", 4'b0000, 4'b0000);
    rd(1, 0, 'h044, 32'h3FF, "R10 ack after reset");
    rd(0, 0, 'h178, 32'h0, "R10 ctl after reset");

    // R1 R3 R5 R7 shared source 30
    wr(0, 0, 'h030, 30);
    wr(0, 0, 'h178, 32'h0000_0201);
    sharedIrq[2] = 1;
    outs("R1 shared src30", 4'b0001, 4'b0010);
    rd(1, 0, 'h044, 30, "R7 ack cpu0");
    rd(1, 1, 'h044, 32'h3FF, "R7 ack cpu1 fiq-only");
    rd(0, 0, 'h178, 32'h201, "R3 ctl readback");

    // R2 clear enable, R1 level behaviour
    wr(0, 0, 'h034, 30);
    outs("R2 enable cleared", 4'b0000, 4'b0000);
    sharedIrq[2] = 0;
    wr(0, 0, 'h030, 30);
    outs("R1 level dropped", 4'b0000, 4'b0000);

    // R2 out-of-range number aliasing source 0
    wr(0, 0, 'h100, 32'h1);
    privIrq[0] = 1;
    wr(0, 0, 'h030, 64);
    outs("R2 number 64 ignored", 4'b0000, 4'b0000);
    wr(0, 0, 'h030, 0);
    outs("R1 src0 enabled", 4'b0001, 4'b0000);
    wr(0, 0, 'h034, 0);
    privIrq[0] = 0;

    // R4 R6 private source 5 gated per CPU
    wr(0, 0, 'h030, 5);
    wr(1, 2, 'h048, 5);
    rd(0, 0, 'h114, 32'h4, "R4 gate set by cpu2");
    privIrq[1*NPRIV+5] = 1;
    outs("R6 cpu1 private line", 4'b0000, 4'b0000);
    privIrq[2*NPRIV+5] = 1;
    outs("R6 cpu2 private line", 4'b0100, 4'b0000);
    wr(1, 3, 'h04C, 5);
    rd(0, 0, 'h114, 32'h4, "R4 clear by cpu3 leaves cpu2");
    outs("R4 cpu2 still open", 4'b0100, 4'b0000);
    wr(1, 2, 'h04C, 5);
    rd(0, 0, 'h114, 32'h0, "R4 clear by cpu2");
    outs("R4 cpu2 closed", 4'b0000, 4'b0000);
    privIrq = '0;

    // R7 priority
    wr(0, 0, 'h030, 3);
    wr(0, 0, 'h030, 7);
    wr(0, 0, 'h10C, 32'h1);
    wr(0, 0, 'h11C, 32'h1);
    privIrq[3] = 1; privIrq[7] = 1;
    rd(1, 0, 'h044, 3, "R7 lowest wins");
    privIrq[3] = 0;
    rd(1, 0, 'h044, 7, "R7 next source");
    privIrq[7] = 0;
    rd(1, 0, 'h044, 32'h3FF, "R7 none pending");

    // R8 R9 doorbells
    wr(0, 0, 'h004, 32'h0500_0009);
    rd(1, 0, 'h008, 32'h200, "R8 cause cpu0");
    rd(1, 1, 'h008, 32'h0, "R8 cause cpu1 untouched");
    rd(1, 2, 'h008, 32'h200, "R8 cause cpu2");
    outs("R9 masked doorbell", 4'b0000, 4'b0000);
    wr(1, 0, 'h00C, 32'h200);
    rd(1, 0, 'h00C, 32'h200, "R9 mask readback");
    outs("R9 unmasked doorbell", 4'b0001, 4'b0000);
    wr(1, 2, 'h008, 32'hFFFF_FFFF);
    rd(1, 2, 'h008, 32'h200, "R9 ones keep cause");
    wr(1, 0, 'h008, 32'hFFFF_FDFF);
    rd(1, 0, 'h008, 32'h0, "R9 zero clears cause");
    outs("R9 doorbell cleared", 4'b0000, 4'b0000);

    // R3 R5 full control word on shared source 32
    wr(0, 0, 'h180, 32'hFFFF_FFFF);
    rd(0, 0, 'h180, 32'h0F0F, "R3 ctl upper bits zero");
    wr(0, 0, 'h030, 32);
    sharedIrq[4] = 1;
    outs("R5 all cpus", 4'b1111, 4'b1111);
    sharedIrq[4] = 0;
    outs("R1 all low again", 4'b0000, 4'b0000);

    running = 0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule